// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block drives four pulse-width modulated pins from one system clock. Software programs it through a small word-wide register bus. The bus has an address, a write strobe and write data, and read data comes back in the same cycle.

Each channel has a 16-bit prescaler that turns the system clock into a stream of one-cycle ticks. An 8-bit step counter advances on each tick and wraps after 256 steps. The pin is high while that counter is below the programmed duty level. One period is therefore the prescale value times 256 clocks, and the high time is the prescale value times the duty level.

Each channel has three control bits:
- an output enable, which releases the pin;
- a run bit, which lets the counters move;
- a force-high bit, which gives a steady full duty.

A channel may also take its step ticks from the prescaler of any other channel. Register writes act at once and do not wait for the end of the running period.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads zero and all four pins are low.
- R2: Word offsets are 0x00 control, 0x04 run, 0x08+4n prescale of channel n, 0x18+4n duty of channel n. Written values read back, unused bits read zero, and reads of any other offset (for example 0x28) return zero. Control bit n is output enable and bit 8+n is force-high. Run bit n is run enable. Prescale bits 15:0 hold the divide value. Duty bits 7:0 hold the level and bits 9:8 hold the tick source.
- R3: With run and output enable set, force-high clear and divide value D≥1, the pin is high for exactly D×L clocks in every window of D×256 clocks, where L is the duty level.
- R4: The step counter wraps from 255 to 0, so a level of 0 gives a pin that is always low and a level of 255 gives 255 high steps out of 256.
- R5: When output enable and force-high are both set, the pin is high on every cycle, whatever the duty level.
- R6: When output enable is clear, the pin is low on every cycle, even with force-high set.
- R7: While run bit n is clear, both counters of channel n are held at zero, so the pin stays high if the level is nonzero and low if the level is zero.
- R8: A divide value of 0 produces no ticks, so the step counter does not move.
- R9: Duty bits 9:8 choose which channel's prescaler advances this channel's step counter.
- R10: A new duty level changes the pin in the cycle after the write, without waiting for the period to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte offset of the register; bits 1:0 are ignored |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, valid in the same cycle |
| pwm_o | output | 4 | Modulated pins, one per channel |

## Verification
The compare path is tested with several pairs of divide value and level, each counted over exactly one period.
- A level of 0 and a level of 255 show that the compare is strict and that the counter wraps.
- Divide values of 2 and 3 show that the prescaler stretches each step rather than the period count.
- A level of 1 catches an off-by-one in the compare.

Directed cases cover the remaining controls:
- force-high against output enable;
- the held counter with run clear;
- a stopped prescaler;
- a channel borrowing another channel's prescaler;
- a duty change observed mid-period.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
   // word indices of the register map (byte offset / 4)
   localparam int IDX_CTL   = 0;
   localparam int IDX_RUN   = 1;
   localparam int IDX_DIV0  = 2;
   // bit position of the first force-high flag in the control word
   localparam int FORCE_LSB = 8;
endpackage

// File: rtl/pwm_quad_div.sv
module pwm_quad_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic             active;

   assign active = run && (div != '0);
   // >= lets a shrunk divide value recover at once
   assign tick   = active && (cnt >= div - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!active) cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + DIV_W'(1);
   end

   p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
   p_no_tick_div0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (div == '0) |-> !tick);
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
   parameter int DUTY_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              adv,
   input  logic              out_en,
   input  logic              force_hi,
   input  logic [DUTY_W-1:0] lvl,
   output logic              pwm
);
   logic [DUTY_W-1:0] step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    step <= '0;
      else if (!run) step <= '0;
      else if (adv)  step <= step + DUTY_W'(1);
   end

   assign pwm = out_en && (force_hi || (step < lvl));

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && adv && (step == '1)) |=> (step == '0));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !adv) |=> $stable(step) || !run);
endmodule

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
   import pwm_quad_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int AW     = 8,
   parameter int DW     = 32,
   parameter int DIV_W  = 16,
   parameter int DUTY_W = 8,
   parameter int SEL_W  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [AW-1:0]                addr,
   input  logic                         wr_en,
   input  logic [DW-1:0]                wdata,
   output logic [DW-1:0]                rdata,
   output logic [NCH-1:0]               out_en_q,
   output logic [NCH-1:0]               force_q,
   output logic [NCH-1:0]               run_q,
   output logic [NCH-1:0][DIV_W-1:0]    div_q,
   output logic [NCH-1:0][DUTY_W-1:0]   lvl_q,
   output logic [NCH-1:0][SEL_W-1:0]    sel_q
);
   localparam int IW       = AW - 2;
   localparam int DUTY_IDX = IDX_DIV0 + NCH;

   logic [IW-1:0] idx;
   logic          unused_bits;

   assign idx         = addr[AW-1:2];
   assign unused_bits = ^{addr[1:0], wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_en_q <= '0;
         force_q  <= '0;
         run_q    <= '0;
         div_q    <= '0;
         lvl_q    <= '0;
         sel_q    <= '0;
      end else if (wr_en) begin
         if (idx == IW'(IDX_CTL)) begin
            out_en_q <= wdata[NCH-1:0];
            force_q  <= wdata[FORCE_LSB +: NCH];
         end
         if (idx == IW'(IDX_RUN)) run_q <= wdata[NCH-1:0];
         for (int n = 0; n < NCH; n++) begin
            if (idx == IW'(IDX_DIV0 + n)) div_q[n] <= wdata[DIV_W-1:0];
            if (idx == IW'(DUTY_IDX + n)) begin
               lvl_q[n] <= wdata[DUTY_W-1:0];
               sel_q[n] <= wdata[DUTY_W +: SEL_W];
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (idx == IW'(IDX_CTL)) begin
         rdata[NCH-1:0]            = out_en_q;
         rdata[FORCE_LSB +: NCH]   = force_q;
      end
      if (idx == IW'(IDX_RUN)) rdata[NCH-1:0] = run_q;
      for (int n = 0; n < NCH; n++) begin
         if (idx == IW'(IDX_DIV0 + n)) rdata[DIV_W-1:0] = div_q[n];
         if (idx == IW'(DUTY_IDX + n)) begin
            rdata[DUTY_W-1:0]      = lvl_q[n];
            rdata[DUTY_W +: SEL_W] = sel_q[n];
         end
      end
   end

   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (idx == IW'(IDX_RUN))) |=> (run_q == $past(wdata[NCH-1:0])));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad #(
   parameter int NCH    = 4,
   parameter int AW     = 8,
   parameter int DW     = 32,
   parameter int DIV_W  = 16,
   parameter int DUTY_W = 8,
   parameter int SEL_W  = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  addr,
   input  logic           wr_en,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata,
   output logic [NCH-1:0] pwm_o
);
   if (NCH < 1 || NCH > (1 << SEL_W)) begin : g_bad_nch
      $error("pwm_quad: NCH must fit the source select field");
   end
   if (DW < DIV_W || DW < 8 + NCH || DW < DUTY_W + SEL_W) begin : g_bad_dw
      $error("pwm_quad: data width too narrow for the fields");
   end
   if (AW - 2 < 4) begin : g_bad_aw
      $error("pwm_quad: address too narrow for the map");
   end

   logic [NCH-1:0]             out_en_q, force_q, run_q, ticks;
   logic [NCH-1:0][DIV_W-1:0]  div_q;
   logic [NCH-1:0][DUTY_W-1:0] lvl_q;
   logic [NCH-1:0][SEL_W-1:0]  sel_q;

   pwm_quad_regs #(
      .NCH(NCH), .AW(AW), .DW(DW), .DIV_W(DIV_W), .DUTY_W(DUTY_W), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .out_en_q(out_en_q), .force_q(force_q), .run_q(run_q),
      .div_q(div_q), .lvl_q(lvl_q), .sel_q(sel_q)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic adv;

      pwm_quad_div #(.DIV_W(DIV_W)) u_div (
         .clk(clk), .rst_n(rst_n), .run(run_q[n]), .div(div_q[n]), .tick(ticks[n])
      );

      assign adv = (int'(sel_q[n]) < NCH) ? ticks[sel_q[n]] : 1'b0;

      pwm_quad_chan #(.DUTY_W(DUTY_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .run(run_q[n]), .adv(adv),
         .out_en(out_en_q[n]), .force_hi(force_q[n]), .lvl(lvl_q[n]),
         .pwm(pwm_o[n])
      );

      p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !out_en_q[n] |-> !pwm_o[n]);
      p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (out_en_q[n] && force_q[n]) |-> pwm_o[n]);
      p_zero_lvl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!force_q[n] && (lvl_q[n] == '0)) |-> !pwm_o[n]);
   end
endmodule

// File: tb/pwm_quad_test.sv
module pwm_quad_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [7:0]  addr = '0;
   logic        wr_en = 0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  pwm_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;   // 50 MHz

   pwm_quad uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
   );

   // one-period vectors for R3/R4: divide value, level, expected high clocks
   localparam int NV = 6;
   localparam int VDIV [NV] = '{1, 1, 1, 2, 3, 1};
   localparam int VLVL [NV] = '{0, 64, 255, 128, 10, 1};
   localparam int VEXP [NV] = '{0, 64, 255, 256, 30, 1};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic [7:0] a, output int v);
      @(negedge clk);
      addr = a;
      #1 v = int'(rdata);
   endtask

   task automatic count_hi(input int ch, input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_o[ch]) hi++;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int v, hi;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      chk("R1 pins", int'(pwm_o), 0);
      rd(8'h00, v); chk("R1 ctl", v, 0);
      rd(8'h04, v); chk("R1 run", v, 0);
      rd(8'h0C, v); chk("R1 div1", v, 0);
      rd(8'h24, v); chk("R1 duty3", v, 0);

      // R2: readback with masking, unmapped offset
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 ctl", v, 32'h0F0F);
      wr(8'h04, 32'hFFFF_FFF0); rd(8'h04, v); chk("R2 run", v, 0);
      wr(8'h14, 32'hABCD_1234); rd(8'h14, v); chk("R2 div3", v, 32'h1234);
      wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); chk("R2 duty1", v, 32'h3FF);
      wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); chk("R2 unmapped", v, 0);
      wr(8'h00, 0); wr(8'h14, 0); wr(8'h1C, 0);

      // R3/R4: table walk on channel 0
      for (int k = 0; k < NV; k++) begin
         wr(8'h04, 0);
         wr(8'h08, VDIV[k]);
         wr(8'h18, VLVL[k]);
         wr(8'h00, 32'h1);
         wr(8'h04, 32'h1);
         count_hi(0, VDIV[k] * 256, hi);
         chk($sformatf("R3 R4 vec%0d", k), hi, VEXP[k]);
      end

      // R5: force-high with output enable
      wr(8'h08, 1); wr(8'h18, 32'h10); wr(8'h00, 32'h101);
      count_hi(0, 256, hi); chk("R5 force", hi, 256);
      // R6: output enable clear wins over force-high
      wr(8'h00, 32'h100);
      count_hi(0, 256, hi); chk("R6 off", hi, 0);

      // R7: run clear holds counters at zero
      wr(8'h00, 32'h1); wr(8'h04, 0);
      count_hi(0, 256, hi); chk("R7 held nonzero", hi, 256);
      wr(8'h18, 0);
      count_hi(0, 256, hi); chk("R7 held zero", hi, 0);

      // R8: divide value 0 stops ticks
      wr(8'h18, 32'h10); wr(8'h08, 0); wr(8'h04, 32'h1);
      count_hi(0, 512, hi); chk("R8 stopped", hi, 512);

      // R9: channel 1 borrows channel 0's prescaler
      wr(8'h04, 0); wr(8'h08, 1); wr(8'h0C, 0);
      wr(8'h1C, 32'h020);                 // source 0, level 32
      wr(8'h00, 32'h2); wr(8'h04, 32'h3);
      count_hi(1, 256, hi); chk("R9 borrowed src", hi, 32);
      wr(8'h1C, 32'h120);                 // own prescaler, divide 0
      count_hi(1, 256, hi); chk("R9 own src", hi, 256);

      // R10: duty change acts mid-period
      wr(8'h04, 0); wr(8'h08, 1); wr(8'h18, 0); wr(8'h00, 32'h1);
      wr(8'h04, 32'h1);
      repeat (5) @(negedge clk);
      chk("R10 before", int'(pwm_o[0]), 0);
      wr(8'h18, 200);
      chk("R10 after", int'(pwm_o[0]), 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule